// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the memory-mapped 32-bit register front end of a multi-channel DMA controller. It holds a small global region (revision, reset-done status, system configuration with a soft-reset trigger, global control, read-only feature words and four interrupt status/enable banks) and a row of identical per-channel windows. Each channel window holds the channel's configuration: control, chaining, interrupt enables, status, port setup, element and frame counts, start addresses, indices and fill colour. It also shows the transfer engine's live progress counters read-only.

Accesses arrive on a request channel with a valid/ready handshake: `req_valid` with `req_ready` high accepts one access. A read returns exactly one response on `rsp_valid`/`rsp_data`. The response is held stable until `rsp_ready`. While a response waits, `req_ready` stays low, so no second access is taken. Writes produce no response. Per-channel configuration leaves on flat packed outputs for the transfer engine. Enable/disable commands, soft reset, a global-control error and a bad-access flag are one-cycle pulses. Status events enter from the engine as per-channel bit vectors.

Top module: `dma_regbank`

## Requirements
- R1: A word-aligned offset below CH_BASE addresses the global region. An offset in [CH_BASE + i*CH_STRIDE, CH_BASE + (i+1)*CH_STRIDE) addresses channel i with local offset (offset - CH_BASE - i*CH_STRIDE). With the default parameters, channel i starts at 0x80 + 0x60*i, so offset 0x200 lies past channel 3.
- R2: Global offset 0x00 reads 0x40 and offset 0x28 reads 1. The feature words read as follows: 0x64 reads 0x000C0000, 0x6C reads 0x1FF, 0x70 reads 0xFF and 0x74 reads 0xFF. Writes to these offsets change nothing.
- R3: A write to 0x2C stores the data ANDed with 0x3321. If bit 1 of that data is set, the write also performs a soft reset. The soft reset returns every other register to its reset value and pulses `soft_rst_pulse` for one cycle.
- R4: The global control register at 0x78 resets to 0x00010010 and keeps written bits under mask 0x00FF00FF. A write whose low byte is zero pulses `cfg_err` for one cycle.
- R5: The channel control register (local 0x00) reads back the written value ANDed with 0x039FF1FF. Its fields are: frame sync at bit 5, priority at 6, enable at 7, suspend at 8, source mode at [13:12], destination mode at [15:14], fill at 16, transparent at 17, block sync at 18, prefetch at 23, source sync at 24 and buffer disable at 25. The 7-bit sync select `cfg_sync` is formed from bits [20:19] (upper two) and [4:0] (lower five).
- R6: Each control-register write pulses the channel's bit of `ch_en_cmd` for one cycle if bit 7 is 1, and of `ch_dis_cmd` if it is 0. Other channels' bits stay low.
- R7: The interrupt-enable register (local 0x08) keeps mask 0x09BE. Engine status bits are recorded in the status register (local 0x0C) only where enabled. Writing 1s to the status register clears those bits.
- R8: Element count (0x14) keeps 24 bits and frame count (0x18) keeps 16 bits. The link register (0x04) keeps bit 15 and bits [4:0]. The port setup register (0x10) keeps [21:0]. Element indices (0x24, 0x2C) keep 16 bits. Addresses (0x1C, 0x20), frame indices (0x28, 0x30) and colour (0x44) keep 32 bits.
- R9: Local offsets 0x34, 0x38, 0x3C and 0x40 return the engine's current source address, destination address, element count and frame count, zero-extended. Writes to them are ignored.
- R10: When a channel records a status event, bit i of interrupt status bank k (0x08 + 4k) sets if bit i of enable bank k (0x18 + 4k) is set. Writing 1s to a status bank clears those bits. `irq[k]` is high whenever bank k is nonzero.
- R11: A read of an unmapped or misaligned offset returns 0 with a one-cycle `bad_access` pulse. A write there changes no register.
- R12: A read response stays valid with stable data until `rsp_ready`. `req_ready` is low while a response is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 32 | Read data |
| bad_access | output | 1 | Pulse: unmapped read |
| soft_rst_pulse | output | 1 | Pulse: soft reset performed |
| cfg_err | output | 1 | Pulse: zero FIFO depth written |
| irq | output | NUM_IRQ | Interrupt lines |
| ch_en_cmd | output | NUM_CH | Pulse: channel enable command |
| ch_dis_cmd | output | NUM_CH | Pulse: channel disable command |
| eng_stat_set | input | NUM_CH*12 | Engine status events per channel |
| eng_cur_src | input | NUM_CH*16 | Current source address low half |
| eng_cur_dst | input | NUM_CH*16 | Current destination address low half |
| eng_cur_elem | input | NUM_CH*24 | Current element counter |
| eng_cur_frame | input | NUM_CH*16 | Current frame counter |
| cfg_ctrl | output | NUM_CH*32 | Control words |
| cfg_sync | output | NUM_CH*7 | Assembled sync select |
| cfg_elem | output | NUM_CH*24 | Element counts |
| cfg_frame | output | NUM_CH*16 | Frame counts |
| cfg_src | output | NUM_CH*32 | Source start addresses |
| cfg_dst | output | NUM_CH*32 | Destination start addresses |
| gcr_out | output | 32 | Global control word |

## Verification
The bench builds the block with NUM_CH=4, CH_BASE=0x80, CH_STRIDE=0x60 and NUM_IRQ=4. This is enough channels that the last window (0x1A0 to 0x1FF) and the first offset past it (0x200) are both reachable. It also lets every interrupt bank map onto a distinct channel mix. Random writes across all four windows, checked against a per-channel model, show that each write lands only in its own window. All four interrupt banks can route the same channel event differently.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int LOC_W  = 7;
  localparam int STAT_W = 12;

  localparam logic [31:0] REV_VAL     = 32'h0000_0040;
  localparam logic [31:0] GCR_RST     = 32'h0001_0010;
  localparam logic [31:0] GCR_MASK    = 32'h00FF_00FF;
  localparam logic [31:0] SYSCFG_MASK = 32'h0000_3321;
  localparam logic [31:0] CTRL_MASK   = 32'h039F_F1FF;
  localparam logic [31:0] DPORT_MASK  = 32'h003F_FFFF;
  localparam logic [STAT_W-1:0] IE_MASK = 12'h9BE;
  localparam logic [31:0] FEAT0 = 32'h000C_0000;
  localparam logic [31:0] FEAT2 = 32'h0000_01FF;
  localparam logic [31:0] FEAT3 = 32'h0000_00FF;
  localparam logic [31:0] FEAT4 = 32'h0000_00FF;

  // global offsets
  localparam logic [6:0] G_REV  = 7'h00;
  localparam logic [6:0] G_IST0 = 7'h08;
  localparam logic [6:0] G_IEN0 = 7'h18;
  localparam logic [6:0] G_SYS  = 7'h28;
  localparam logic [6:0] G_CFG  = 7'h2C;
  localparam logic [6:0] G_FT0  = 7'h64;
  localparam logic [6:0] G_FT2  = 7'h6C;
  localparam logic [6:0] G_FT3  = 7'h70;
  localparam logic [6:0] G_FT4  = 7'h74;
  localparam logic [6:0] G_GCR  = 7'h78;

  // channel local offsets
  localparam logic [LOC_W-1:0] L_CTRL  = 7'h00;
  localparam logic [LOC_W-1:0] L_LINK  = 7'h04;
  localparam logic [LOC_W-1:0] L_IE    = 7'h08;
  localparam logic [LOC_W-1:0] L_STAT  = 7'h0C;
  localparam logic [LOC_W-1:0] L_DPORT = 7'h10;
  localparam logic [LOC_W-1:0] L_ELEM  = 7'h14;
  localparam logic [LOC_W-1:0] L_FRAME = 7'h18;
  localparam logic [LOC_W-1:0] L_SRC   = 7'h1C;
  localparam logic [LOC_W-1:0] L_DST   = 7'h20;
  localparam logic [LOC_W-1:0] L_SEI   = 7'h24;
  localparam logic [LOC_W-1:0] L_SFI   = 7'h28;
  localparam logic [LOC_W-1:0] L_DEI   = 7'h2C;
  localparam logic [LOC_W-1:0] L_DFI   = 7'h30;
  localparam logic [LOC_W-1:0] L_CSRC  = 7'h34;
  localparam logic [LOC_W-1:0] L_CDST  = 7'h38;
  localparam logic [LOC_W-1:0] L_CELEM = 7'h3C;
  localparam logic [LOC_W-1:0] L_CFRM  = 7'h40;
  localparam logic [LOC_W-1:0] L_COLOR = 7'h44;

  typedef struct packed {
    logic [31:0]       ctrl;
    logic              lnk_en;
    logic [4:0]        lnk_next;
    logic [STAT_W-1:0] ie;
    logic [STAT_W-1:0] stat;
    logic [21:0]       dport;
    logic [23:0]       elem;
    logic [15:0]       frame;
    logic [31:0]       src;
    logic [31:0]       dst;
    logic [15:0]       sei;
    logic [31:0]       sfi;
    logic [15:0]       dei;
    logic [31:0]       dfi;
    logic [31:0]       color;
  } chan_regs_t;
endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode #(
  parameter int ADDR_W    = 12,
  parameter int NUM_CH    = 4,
  parameter int CH_BASE   = 'h80,
  parameter int CH_STRIDE = 'h60,
  localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              glob_hit,
  output logic              ch_hit,
  output logic [IDX_W-1:0]  ch_idx,
  output logic [6:0]        loc
);
  logic        aligned;
  logic [31:0] a32;
  logic [31:0] diff;

  always_comb begin
    aligned  = (addr[1:0] == 2'b00);
    a32      = 32'(addr);
    glob_hit = aligned && (a32 < 32'(CH_BASE));
    ch_hit   = 1'b0;
    ch_idx   = '0;
    loc      = '0;
    diff     = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (aligned && a32 >= 32'(CH_BASE + i*CH_STRIDE) &&
          a32 < 32'(CH_BASE + (i+1)*CH_STRIDE)) begin
        ch_hit = 1'b1;
        ch_idx = IDX_W'(i);
        diff   = a32 - 32'(CH_BASE + i*CH_STRIDE);
        loc    = diff[6:0];
      end
    end
  end
endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_sel,
  input  logic [LOC_W-1:0]  loc,
  input  logic [31:0]       wdata,
  input  logic [STAT_W-1:0] stat_set,
  input  logic [15:0]       cur_src,
  input  logic [15:0]       cur_dst,
  input  logic [23:0]       cur_elem,
  input  logic [15:0]       cur_frame,
  output logic [31:0]       rd_data,
  output logic              rd_hit,
  output logic              en_cmd,
  output logic              dis_cmd,
  output logic              evt,
  output logic [31:0]       ctrl_o,
  output logic [6:0]        sync_o,
  output logic [23:0]       elem_o,
  output logic [15:0]       frame_o,
  output logic [31:0]       src_o,
  output logic [31:0]       dst_o
);
  chan_regs_t        q;
  logic [STAT_W-1:0] set_eff;
  logic [STAT_W-1:0] stat_clr;

  assign set_eff  = stat_set & q.ie;
  assign evt      = |set_eff;
  assign stat_clr = (wr_sel && loc == L_STAT) ? wdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      en_cmd  <= 1'b0;
      dis_cmd <= 1'b0;
    end else if (soft_clr) begin
      q       <= '0;
      en_cmd  <= 1'b0;
      dis_cmd <= 1'b0;
    end else begin
      en_cmd  <= 1'b0;
      dis_cmd <= 1'b0;
      q.stat  <= (q.stat & ~stat_clr) | set_eff;
      if (wr_sel) begin
        case (loc)
          L_CTRL: begin
            q.ctrl  <= wdata & CTRL_MASK;
            en_cmd  <= wdata[7];
            dis_cmd <= ~wdata[7];
          end
          L_LINK: begin
            q.lnk_en   <= wdata[15];
            q.lnk_next <= wdata[4:0];
          end
          L_IE:    q.ie    <= wdata[STAT_W-1:0] & IE_MASK;
          L_DPORT: q.dport <= wdata[21:0];
          L_ELEM:  q.elem  <= wdata[23:0];
          L_FRAME: q.frame <= wdata[15:0];
          L_SRC:   q.src   <= wdata;
          L_DST:   q.dst   <= wdata;
          L_SEI:   q.sei   <= wdata[15:0];
          L_SFI:   q.sfi   <= wdata;
          L_DEI:   q.dei   <= wdata[15:0];
          L_DFI:   q.dfi   <= wdata;
          L_COLOR: q.color <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (loc)
      L_CTRL:  rd_data = q.ctrl;
      L_LINK:  rd_data = {16'b0, q.lnk_en, 10'b0, q.lnk_next};
      L_IE:    rd_data = 32'(q.ie);
      L_STAT:  rd_data = 32'(q.stat);
      L_DPORT: rd_data = 32'(q.dport);
      L_ELEM:  rd_data = 32'(q.elem);
      L_FRAME: rd_data = 32'(q.frame);
      L_SRC:   rd_data = q.src;
      L_DST:   rd_data = q.dst;
      L_SEI:   rd_data = 32'(q.sei);
      L_SFI:   rd_data = q.sfi;
      L_DEI:   rd_data = 32'(q.dei);
      L_DFI:   rd_data = q.dfi;
      L_CSRC:  rd_data = 32'(cur_src);
      L_CDST:  rd_data = 32'(cur_dst);
      L_CELEM: rd_data = 32'(cur_elem);
      L_CFRM:  rd_data = 32'(cur_frame);
      L_COLOR: rd_data = q.color;
      default: rd_hit  = 1'b0;
    endcase
  end

  assign ctrl_o  = q.ctrl;
  assign sync_o  = {q.ctrl[20:19], q.ctrl[4:0]};
  assign elem_o  = q.elem;
  assign frame_o = q.frame;
  assign src_o   = q.src;
  assign dst_o   = q.dst;

  // R6
  ctrl_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !soft_clr && loc == L_CTRL) |=>
      (en_cmd == $past(wdata[7])) && (dis_cmd == !$past(wdata[7])));
  // R6
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_cmd && dis_cmd));
  // R7
  stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !soft_clr && loc == L_STAT && stat_set == '0) |=>
      q.stat == ($past(q.stat) & ~$past(wdata[STAT_W-1:0])));
endmodule

// File: rtl/dma_rb_global.sv
module dma_rb_global
  import dma_rb_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_clr,
  input  logic               wr_sel,
  input  logic [6:0]         addr,
  input  logic [31:0]        wdata,
  input  logic [NUM_CH-1:0]  ch_evt,
  output logic [31:0]        rd_data,
  output logic               rd_hit,
  output logic               cfg_err,
  output logic [NUM_IRQ-1:0] irq,
  output logic [31:0]        gcr_o
);
  logic [31:0]       sys_cfg_q;
  logic [31:0]       gcr_q;
  logic [NUM_CH-1:0] ien_q  [NUM_IRQ];
  logic [NUM_CH-1:0] ist_q  [NUM_IRQ];
  logic [NUM_CH-1:0] ist_clr[NUM_IRQ];

  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++)
      ist_clr[k] = (wr_sel && addr == 7'(G_IST0 + 4*k)) ? wdata[NUM_CH-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_cfg_q <= '0;
      gcr_q     <= GCR_RST;
      cfg_err   <= 1'b0;
      for (int k = 0; k < NUM_IRQ; k++) begin
        ien_q[k] <= '0;
        ist_q[k] <= '0;
      end
    end else if (soft_clr) begin
      sys_cfg_q <= wdata & SYSCFG_MASK;
      gcr_q     <= GCR_RST;
      cfg_err   <= 1'b0;
      for (int k = 0; k < NUM_IRQ; k++) begin
        ien_q[k] <= '0;
        ist_q[k] <= '0;
      end
    end else begin
      cfg_err <= wr_sel && addr == G_GCR && wdata[7:0] == 8'h00;
      if (wr_sel && addr == G_CFG) sys_cfg_q <= wdata & SYSCFG_MASK;
      if (wr_sel && addr == G_GCR) gcr_q     <= wdata & GCR_MASK;
      for (int k = 0; k < NUM_IRQ; k++) begin
        if (wr_sel && addr == 7'(G_IEN0 + 4*k)) ien_q[k] <= wdata[NUM_CH-1:0];
        ist_q[k] <= (ist_q[k] & ~ist_clr[k]) | (ien_q[k] & ch_evt);
      end
    end
  end

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = '0;
    case (addr)
      G_REV:   rd_data = REV_VAL;
      G_SYS:   rd_data = 32'd1;
      G_CFG:   rd_data = sys_cfg_q;
      G_FT0:   rd_data = FEAT0;
      G_FT2:   rd_data = FEAT2;
      G_FT3:   rd_data = FEAT3;
      G_FT4:   rd_data = FEAT4;
      G_GCR:   rd_data = gcr_q;
      default: rd_hit  = 1'b0;
    endcase
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (addr == 7'(G_IST0 + 4*k)) begin
        rd_hit  = 1'b1;
        rd_data = 32'(ist_q[k]);
      end
      if (addr == 7'(G_IEN0 + 4*k)) begin
        rd_hit  = 1'b1;
        rd_data = 32'(ien_q[k]);
      end
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
    assign irq[k] = |ist_q[k];
  end
  assign gcr_o = gcr_q;

  // R4
  gcr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && !soft_clr && addr == G_GCR) |=> gcr_q == ($past(wdata) & GCR_MASK));
  // R4
  cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> gcr_q[7:0] == 8'h00);
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_CH    = 4,
  parameter int CH_BASE   = 'h80,
  parameter int CH_STRIDE = 'h60,
  parameter int NUM_IRQ   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_data,
  output logic                   bad_access,
  output logic                   soft_rst_pulse,
  output logic                   cfg_err,
  output logic [NUM_IRQ-1:0]     irq,
  output logic [NUM_CH-1:0]      ch_en_cmd,
  output logic [NUM_CH-1:0]      ch_dis_cmd,
  input  logic [NUM_CH*12-1:0]   eng_stat_set,
  input  logic [NUM_CH*16-1:0]   eng_cur_src,
  input  logic [NUM_CH*16-1:0]   eng_cur_dst,
  input  logic [NUM_CH*24-1:0]   eng_cur_elem,
  input  logic [NUM_CH*16-1:0]   eng_cur_frame,
  output logic [NUM_CH*32-1:0]   cfg_ctrl,
  output logic [NUM_CH*7-1:0]    cfg_sync,
  output logic [NUM_CH*24-1:0]   cfg_elem,
  output logic [NUM_CH*16-1:0]   cfg_frame,
  output logic [NUM_CH*32-1:0]   cfg_src,
  output logic [NUM_CH*32-1:0]   cfg_dst,
  output logic [31:0]            gcr_out
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              acc, wr_acc, rd_acc, soft_req;
  logic              glob_hit, ch_hit;
  logic [IDX_W-1:0]  ch_idx;
  logic [6:0]        loc;
  logic [31:0]       g_rd;
  logic              g_rh;
  logic [31:0]       c_rd [NUM_CH];
  logic [NUM_CH-1:0] c_rh;
  logic [NUM_CH-1:0] c_evt;
  logic [31:0]       rd_mux;
  logic              rd_ok;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;
  assign soft_req  = wr_acc && glob_hit && req_addr[6:0] == G_CFG && req_wdata[1];

  dma_rb_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)
  ) u_dec (
    .addr(req_addr), .glob_hit(glob_hit), .ch_hit(ch_hit), .ch_idx(ch_idx), .loc(loc)
  );

  dma_rb_global #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_glob (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_req),
    .wr_sel(wr_acc && glob_hit), .addr(req_addr[6:0]), .wdata(req_wdata),
    .ch_evt(c_evt), .rd_data(g_rd), .rd_hit(g_rh), .cfg_err(cfg_err),
    .irq(irq), .gcr_o(gcr_out)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_rb_chan u_ch (
      .clk(clk), .rst_n(rst_n), .soft_clr(soft_req),
      .wr_sel(wr_acc && ch_hit && ch_idx == IDX_W'(i)),
      .loc(loc), .wdata(req_wdata),
      .stat_set(eng_stat_set[i*12 +: 12]),
      .cur_src(eng_cur_src[i*16 +: 16]), .cur_dst(eng_cur_dst[i*16 +: 16]),
      .cur_elem(eng_cur_elem[i*24 +: 24]), .cur_frame(eng_cur_frame[i*16 +: 16]),
      .rd_data(c_rd[i]), .rd_hit(c_rh[i]),
      .en_cmd(ch_en_cmd[i]), .dis_cmd(ch_dis_cmd[i]), .evt(c_evt[i]),
      .ctrl_o(cfg_ctrl[i*32 +: 32]), .sync_o(cfg_sync[i*7 +: 7]),
      .elem_o(cfg_elem[i*24 +: 24]), .frame_o(cfg_frame[i*16 +: 16]),
      .src_o(cfg_src[i*32 +: 32]), .dst_o(cfg_dst[i*32 +: 32])
    );
  end

  always_comb begin
    rd_ok  = 1'b0;
    rd_mux = '0;
    if (glob_hit) begin
      rd_ok  = g_rh;
      rd_mux = g_rd;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_hit && ch_idx == IDX_W'(i)) begin
          rd_ok  = c_rh[i];
          rd_mux = c_rd[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_data       <= '0;
      bad_access     <= 1'b0;
      soft_rst_pulse <= 1'b0;
    end else begin
      bad_access     <= rd_acc && !rd_ok;
      soft_rst_pulse <= soft_req;
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_ok ? rd_mux : 32'h0;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R11
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (rsp_valid && rsp_data == 32'h0));
  // R3
  soft_def_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_pulse |-> (gcr_out == GCR_RST && cfg_ctrl == '0));
  // R1
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(glob_hit && ch_hit));
endmodule

// File: tb/dma_regbank_tb.sv
`timescale 1ns/1ps
module dma_regbank_tb;
  localparam int NCH = 4;
  localparam int NIRQ = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic req_ready, rsp_valid, bad_access, soft_rst_pulse, cfg_err;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_data, gcr_out;
  logic [NIRQ-1:0] irq;
  logic [NCH-1:0] ch_en_cmd, ch_dis_cmd;
  logic [NCH*12-1:0] eng_stat_set = '0;
  logic [NCH*16-1:0] eng_cur_src, eng_cur_dst, eng_cur_frame;
  logic [NCH*24-1:0] eng_cur_elem;
  logic [NCH*32-1:0] cfg_ctrl, cfg_src, cfg_dst;
  logic [NCH*7-1:0]  cfg_sync;
  logic [NCH*24-1:0] cfg_elem;
  logic [NCH*16-1:0] cfg_frame;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] model [NCH][13];

  always #4 clk = ~clk;

  dma_regbank #(.ADDR_W(12), .NUM_CH(NCH), .CH_BASE('h80), .CH_STRIDE('h60), .NUM_IRQ(NIRQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .bad_access(bad_access), .soft_rst_pulse(soft_rst_pulse), .cfg_err(cfg_err),
    .irq(irq), .ch_en_cmd(ch_en_cmd), .ch_dis_cmd(ch_dis_cmd),
    .eng_stat_set(eng_stat_set), .eng_cur_src(eng_cur_src), .eng_cur_dst(eng_cur_dst),
    .eng_cur_elem(eng_cur_elem), .eng_cur_frame(eng_cur_frame),
    .cfg_ctrl(cfg_ctrl), .cfg_sync(cfg_sync), .cfg_elem(cfg_elem), .cfg_frame(cfg_frame),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .gcr_out(gcr_out)
  );

  function automatic logic [11:0] off_of(int r);
    case (r)
      0: return 12'h00;  1: return 12'h04;  2: return 12'h08;  3: return 12'h10;
      4: return 12'h14;  5: return 12'h18;  6: return 12'h1C;  7: return 12'h20;
      8: return 12'h24;  9: return 12'h28; 10: return 12'h2C; 11: return 12'h30;
      default: return 12'h44;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(int r);
    case (r)
      0: return 32'h039F_F1FF;  1: return 32'h0000_801F;  2: return 32'h0000_09BE;
      3: return 32'h003F_FFFF;  4: return 32'h00FF_FFFF;  5: return 32'h0000_FFFF;
      8, 10: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [11:0] ch_addr(int c, logic [11:0] lo);
    return 12'(12'h80 + c*12'h60) + lo;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic bad);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    d = rsp_data; bad = bad_access;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d; logic b;
    rd(a, d, b);
    check(req, d, exp);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=complete");
    finish_up();
  end

  initial begin
    logic [31:0] d, v; logic b;
    int c, r;
    for (int i = 0; i < NCH; i++) begin
      eng_cur_src[i*16 +: 16]   = 16'hA000 + 16'(i);
      eng_cur_dst[i*16 +: 16]   = 16'hB000 + 16'(i);
      eng_cur_elem[i*24 +: 24]  = 24'h0C0000 + 24'(i);
      eng_cur_frame[i*16 +: 16] = 16'hD000 + 16'(i);
    end
    for (int i = 0; i < NCH; i++) for (int j = 0; j < 13; j++) model[i][j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 / R4 reset values and constants
    rchk("R2 revision", 12'h00, 32'h40);
    rchk("R2 sysstatus", 12'h28, 32'h1);
    rchk("R2 feat0", 12'h64, 32'h000C_0000);
    rchk("R2 feat2", 12'h6C, 32'h1FF);
    rchk("R2 feat3", 12'h70, 32'hFF);
    rchk("R2 feat4", 12'h74, 32'hFF);
    rchk("R4 gcr reset", 12'h78, 32'h0001_0010);
    rchk("R3 syscfg reset", 12'h2C, 32'h0);
    rchk("R5 ctrl reset", ch_addr(0, 12'h00), 32'h0);
    wr(12'h00, 32'hFFFF_FFFF);
    wr(12'h64, 32'h0);
    rchk("R2 revision write ignored", 12'h00, 32'h40);
    rchk("R2 feat0 write ignored", 12'h64, 32'h000C_0000);

    // R3 syscfg mask without reset
    wr(12'h2C, 32'hFFFF_FFFD);
    check("R3 no soft pulse", 32'(soft_rst_pulse), 32'h0);
    rchk("R3 syscfg mask", 12'h2C, 32'h3321);

    // R4 gcr
    wr(12'h78, 32'hFFFF_FFFF);
    check("R4 no cfg_err", 32'(cfg_err), 32'h0);
    rchk("R4 gcr mask", 12'h78, 32'h00FF_00FF);
    wr(12'h78, 32'h1234_5600);
    check("R4 cfg_err pulse", 32'(cfg_err), 32'h1);
    @(negedge clk);
    check("R4 cfg_err one cycle", 32'(cfg_err), 32'h0);
    rchk("R4 gcr low zero", 12'h78, 32'h0034_0000);

    // R5 / R6 control
    wr(ch_addr(2, 12'h00), 32'hFFFF_FFFF);
    check("R6 en pulse ch2", 32'(ch_en_cmd), 32'h4);
    check("R6 no dis", 32'(ch_dis_cmd), 32'h0);
    check("R5 sync assembly", 32'(cfg_sync[2*7 +: 7]), 32'h7F);
    @(negedge clk);
    check("R6 en one cycle", 32'(ch_en_cmd), 32'h0);
    rchk("R5 ctrl mask", ch_addr(2, 12'h00), 32'h039F_F1FF);
    wr(ch_addr(1, 12'h00), 32'h0010_0005);
    check("R6 dis pulse ch1", 32'(ch_dis_cmd), 32'h2);
    check("R6 no en", 32'(ch_en_cmd), 32'h0);
    check("R5 sync split", 32'(cfg_sync[1*7 +: 7]), 32'h45);
    model[2][0] = 32'h039F_F1FF;
    model[1][0] = 32'h0010_0005;

    // R9 read-only progress counters
    for (int i = 0; i < NCH; i++) begin
      wr(ch_addr(i, 12'h34), 32'hFFFF_FFFF);
      rchk("R9 cur src", ch_addr(i, 12'h34), 32'hA000 + 32'(i));
      rchk("R9 cur dst", ch_addr(i, 12'h38), 32'hB000 + 32'(i));
      rchk("R9 cur elem", ch_addr(i, 12'h3C), 32'h0C0000 + 32'(i));
      rchk("R9 cur frame", ch_addr(i, 12'h40), 32'hD000 + 32'(i));
    end

    // R7 / R10 status and interrupts
    wr(ch_addr(2, 12'h08), 32'hFFFF_FFFF);
    rchk("R7 ie mask", ch_addr(2, 12'h08), 32'h9BE);
    wr(ch_addr(2, 12'h08), 32'h0000_0008);
    model[2][2] = 32'h8;
    wr(12'h1C, 32'h4);   // bank1 enables ch2
    wr(12'h18, 32'h2);   // bank0 enables ch1 only
    @(negedge clk);
    eng_stat_set[2*12 +: 12] = 12'h00A;
    @(negedge clk);
    eng_stat_set = '0;
    check("R10 irq lines", 32'(irq), 32'h2);
    rchk("R7 status masked by ie", ch_addr(2, 12'h0C), 32'h8);
    rchk("R10 bank1 status", 12'h0C, 32'h4);
    rchk("R10 bank0 status", 12'h08, 32'h0);
    wr(ch_addr(2, 12'h0C), 32'h8);
    rchk("R7 status w1c", ch_addr(2, 12'h0C), 32'h0);
    wr(12'h0C, 32'h4);
    check("R10 irq cleared", 32'(irq), 32'h0);
    rchk("R10 bank1 cleared", 12'h0C, 32'h0);

    // R11 unmapped accesses
    rd(12'h04, d, b);  check("R11 unmapped 0x04 data", d, 0); check("R11 bad 0x04", 32'(b), 1);
    rd(12'h200, d, b); check("R11 past last ch data", d, 0); check("R11 bad 0x200", 32'(b), 1);
    rd(ch_addr(3, 12'h48), d, b); check("R11 local hole", 32'(b), 1);
    rd(12'h7A, d, b);  check("R11 misaligned", 32'(b), 1);
    @(negedge clk);
    check("R11 bad one cycle", 32'(bad_access), 0);
    rd(12'h78, d, b);  check("R11 mapped not bad", 32'(b), 0);
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h7A, 32'h0000_0001);
    rchk("R11 write ignored gcr", 12'h78, 32'h0034_0000);

    // R12 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 12'h00;
    @(posedge clk); @(negedge clk);
    req_addr = 12'h28;
    check("R12 stalled ready low", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    check("R12 held valid", 32'(rsp_valid), 1);
    check("R12 held data", rsp_data, 32'h40);
    req_valid = 0;
    rsp_ready = 1;
    @(negedge clk);
    check("R12 released", 32'(rsp_valid), 0);

    // R1 / R8 random traffic across windows
    v = $urandom(32'h5EED_1234);
    for (int n = 0; n < 240; n++) begin
      c = int'($urandom % NCH);
      r = int'($urandom % 13);
      v = $urandom;
      if (n < 8) begin r = 4 + (n % 2); v = 32'hFFFF_FFFF; end
      wr(ch_addr(c, off_of(r)), v);
      model[c][r] = v & mask_of(r);
      rchk(r == 0 ? "R5 rand ctrl" : "R8 rand field", ch_addr(c, off_of(r)), model[c][r]);
    end
    for (int i = 0; i < NCH; i++)
      for (int j = 0; j < 13; j++)
        rchk("R1 window isolation", ch_addr(i, off_of(j)), model[i][j]);
    for (int i = 0; i < NCH; i++) begin
      check("R1 cfg_src port", cfg_src[i*32 +: 32], model[i][6]);
      check("R8 cfg_elem port", 32'(cfg_elem[i*24 +: 24]), model[i][4]);
    end

    // R3 soft reset
    wr(12'h2C, 32'h0000_1002);
    check("R3 soft pulse", 32'(soft_rst_pulse), 1);
    @(negedge clk);
    check("R3 soft one cycle", 32'(soft_rst_pulse), 0);
    rchk("R3 syscfg after soft", 12'h2C, 32'h1000);
    rchk("R3 gcr default", 12'h78, 32'h0001_0010);
    rchk("R3 bank0 enable cleared", 12'h18, 32'h0);
    for (int i = 0; i < NCH; i++) begin
      rchk("R3 ctrl cleared", ch_addr(i, 12'h00), 32'h0);
      rchk("R3 src cleared", ch_addr(i, 12'h1C), 32'h0);
    end

    finish_up();
  end
endmodule